// File: doc/BRIEF.md
# In-Order Graduation List

This block is the bookkeeping queue that sits between register renaming and graduation in an out-of-order core. Every instruction gets a slot when it is decoded, in program order. The slot holds three things: the physical register that its destination named before renaming, whether it has a destination at all, and the tag of the branch it belongs to. The slot index handed back at decode is the handle that execution later uses to report that the instruction has completed, and whether it raised an exception.

Each cycle the block looks at the oldest slots and graduates, in order, as many completed and exception-free entries as the per-cycle limit allows. For each graduating entry it reports the old physical register so the free list can take it back. A mispredicted branch cuts the queue back so that the branch is the youngest entry. An entry whose exception flag is set is acted on only once it is the oldest entry. It then raises a one-cycle exception pulse carrying its slot index and empties the whole queue.

Top module: `inorder_retire_list`

## Requirements
- R1: After reset the list is empty, `dec_ready` is 1, `ret_valid` is all zeros and `exc_valid` is 0.
- R2: An accepted decode writes the slot shown on `dec_idx`, which then advances by one modulo DEPTH. A newly written slot starts not completed, even if its previous occupant had completed.
- R3: After DEPTH decodes with no graduation, `dec_ready` is 0. A decode offered then is dropped and never graduates. The occupancy never exceeds DEPTH.
- R4: Entries graduate strictly in slot order. A completed entry never graduates while an older entry is still incomplete.
- R5: At most RET_W entries graduate per edge. Slot k of the graduation outputs carries the k-th oldest of them, so `ret_valid` is always of the form 0…01…1.
- R6: Graduation in an edge stops at the first entry that is incomplete or flagged with an exception, even if graduation slots remain.
- R7: For each graduating entry, `ret_ptag` gives the previous physical register stored at decode and `ret_btag` gives its branch tag. The `ret_free` bit is 1 only if the entry had a destination (bit k of `ret_free` belongs to slot k).
- R8: When `mis_valid` is high, every entry younger than the entry at `mis_idx` is removed, and the next decode reuses the slot after it. In that edge, neither a decode nor a graduation takes place.
- R9: An entry flagged with an exception raises nothing until it is the oldest. When it reaches the head and has completed, `exc_valid` pulses for one cycle with `exc_idx` equal to its slot. All entries are then discarded, nothing graduates in that edge, and the next decode reuses that slot.
- R10: The graduation and exception outputs are registered. An entry completed at edge N graduates at edge N+1 at the earliest, and is visible on the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode offers a new entry |
| dec_old_ptag | input | PTAG_W | Physical register the destination mapped to before renaming |
| dec_has_dst | input | 1 | Instruction writes a destination register |
| dec_btag | input | BTAG_W | Branch tag of the instruction |
| dec_ready | output | 1 | List has room for a decode |
| dec_idx | output | IDX_W | Slot the next accepted decode will occupy |
| cmp_valid | input | 1 | Completion report |
| cmp_idx | input | IDX_W | Slot that completed |
| cmp_exc | input | 1 | Completed instruction raised an exception |
| mis_valid | input | 1 | Branch misprediction |
| mis_idx | input | IDX_W | Slot of the mispredicted branch |
| ret_valid | output | RET_W | Graduation slot k is valid |
| ret_free | output | RET_W | Graduation slot k releases a register |
| ret_ptag | output | RET_W*PTAG_W | Register to release, slot k at bits k*PTAG_W |
| ret_btag | output | RET_W*BTAG_W | Branch tag of the graduating entry, slot k at bits k*BTAG_W |
| exc_valid | output | 1 | Precise exception taken (one-cycle pulse) |
| exc_idx | output | IDX_W | Slot of the excepting entry |

## Verification
Some properties are checked on every cycle. The occupancy never exceeds the depth. The graduation valid vector stays contiguous from slot 0. A release is never flagged on an invalid slot. The queue is empty whenever the exception pulse is out, and nothing graduates alongside it. Nothing graduates right after a misprediction, and the outputs are idle after reset. Other behaviour only the bench scenarios can show: which register numbers come out and in what order, the blocking effect of an incomplete or excepting older entry, the slot reuse after truncation and after an exception flush, that a decode offered while full is dropped, and the one-edge delay between completion and graduation.

// File: rtl/grl_pkg.sv
package grl_pkg;
  // What the list does at the next edge; exactly one applies.
  typedef enum logic [1:0] {
    ACT_RUN   = 2'd0,  // normal: decode, complete, graduate
    ACT_TRUNC = 2'd1,  // misprediction: cut tail back to the branch
    ACT_FLUSH = 2'd2   // exception at head: discard everything
  } grl_act_e;
endpackage

// File: rtl/grl_payload.sv
// Per-slot payload written once at decode and read by the graduation slots.
module grl_payload #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int RD    = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic [RD*IDX_W-1:0] rd_idx,
  output logic [RD*DW-1:0]    rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < RD; g++) begin : g_rd
    assign rd_data[g*DW +: DW] = mem[rd_idx[g*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/grl_flags.sv
// Completion and exception flags, one pair per slot.
module grl_flags #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx,
  input  logic             mark_exc,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] exc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= '0;
      exc_o  <= '0;
    end else begin
      if (alloc_en) begin
        done_o[alloc_idx] <= 1'b0;
        exc_o[alloc_idx]  <= 1'b0;
      end
      if (mark_en) begin
        done_o[mark_idx] <= 1'b1;
        exc_o[mark_idx]  <= mark_exc;
      end
    end
  end
endmodule

// File: rtl/grl_scan.sv
// Looks at the RET_W oldest slots and picks the in-order run that may graduate.
module grl_scan #(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PW    = IDX_W + 1
) (
  input  logic [IDX_W-1:0]       head_idx,
  input  logic [PW-1:0]          occ,
  input  logic [DEPTH-1:0]       done,
  input  logic [DEPTH-1:0]       exc,
  output logic [RET_W-1:0]       grant,
  output logic [PW-1:0]          n_ret,
  output logic [RET_W*IDX_W-1:0] slot_idx,
  output logic                   head_exc
);
  always_comb begin
    logic run;
    run      = 1'b1;
    grant    = '0;
    n_ret    = '0;
    slot_idx = '0;
    for (int k = 0; k < RET_W; k++) begin
      logic [IDX_W-1:0] ix;
      ix = head_idx + IDX_W'(k);
      slot_idx[k*IDX_W +: IDX_W] = ix;
      if (run && (PW'(k) < occ) && done[ix] && !exc[ix]) begin
        grant[k] = 1'b1;
        n_ret    = n_ret + PW'(1);
      end else begin
        run = 1'b0;
      end
    end
    head_exc = (occ != '0) && done[head_idx] && exc[head_idx];
  end
endmodule

// File: rtl/inorder_retire_list.sv
module inorder_retire_list
  import grl_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PTAG_W = 7,
  parameter int BTAG_W = 3,
  parameter int RET_W  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dec_valid,
  input  logic [PTAG_W-1:0]       dec_old_ptag,
  input  logic                    dec_has_dst,
  input  logic [BTAG_W-1:0]       dec_btag,
  output logic                    dec_ready,
  output logic [IDX_W-1:0]        dec_idx,
  input  logic                    cmp_valid,
  input  logic [IDX_W-1:0]        cmp_idx,
  input  logic                    cmp_exc,
  input  logic                    mis_valid,
  input  logic [IDX_W-1:0]        mis_idx,
  output logic [RET_W-1:0]        ret_valid,
  output logic [RET_W-1:0]        ret_free,
  output logic [RET_W*PTAG_W-1:0] ret_ptag,
  output logic [RET_W*BTAG_W-1:0] ret_btag,
  output logic                    exc_valid,
  output logic [IDX_W-1:0]        exc_idx
);
  localparam int PW = IDX_W + 1;          // pointer with wrap bit
  localparam int DW = 1 + BTAG_W + PTAG_W; // {has_dst, btag, ptag}

  logic [PW-1:0] head_q, tail_q, head_n, tail_n, occ;
  logic [IDX_W-1:0] head_idx, br_off;
  logic full, dec_fire, mark_en;
  grl_act_e act;

  logic [DEPTH-1:0] done_v, exc_v;
  logic [RET_W-1:0] grant;
  logic [PW-1:0] n_ret;
  logic [RET_W*IDX_W-1:0] slot_idx;
  logic head_exc;
  logic [RET_W*DW-1:0] slot_data;

  assign head_idx  = head_q[IDX_W-1:0];
  assign occ       = tail_q - head_q;
  assign full      = (occ == PW'(DEPTH));
  assign dec_ready = !full;
  assign dec_idx   = tail_q[IDX_W-1:0];

  always_comb begin
    if (head_exc)       act = ACT_FLUSH;
    else if (mis_valid) act = ACT_TRUNC;
    else                act = ACT_RUN;
  end

  assign dec_fire = dec_valid && !full && (act == ACT_RUN);
  assign mark_en  = cmp_valid && (act != ACT_FLUSH);
  assign br_off   = mis_idx - head_idx;

  always_comb begin
    head_n = head_q;
    tail_n = tail_q;
    unique case (act)
      ACT_FLUSH: tail_n = head_q;
      ACT_TRUNC: tail_n = head_q + PW'(br_off) + PW'(1);
      default: begin
        head_n = head_q + n_ret;
        tail_n = tail_q + PW'(dec_fire);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  grl_payload #(.DEPTH(DEPTH), .DW(DW), .RD(RET_W)) u_payload (
    .clk     (clk),
    .wr_en   (dec_fire),
    .wr_idx  (dec_idx),
    .wr_data ({dec_has_dst, dec_btag, dec_old_ptag}),
    .rd_idx  (slot_idx),
    .rd_data (slot_data)
  );

  grl_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (dec_fire),
    .alloc_idx (dec_idx),
    .mark_en   (mark_en),
    .mark_idx  (cmp_idx),
    .mark_exc  (cmp_exc),
    .done_o    (done_v),
    .exc_o     (exc_v)
  );

  grl_scan #(.DEPTH(DEPTH), .RET_W(RET_W)) u_scan (
    .head_idx (head_idx),
    .occ      (occ),
    .done     (done_v),
    .exc      (exc_v),
    .grant    (grant),
    .n_ret    (n_ret),
    .slot_idx (slot_idx),
    .head_exc (head_exc)
  );

  // Registered graduation and exception outputs.
  for (genvar g = 0; g < RET_W; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        ret_valid[g] <= 1'b0;
        ret_free[g]  <= 1'b0;
        ret_ptag[g*PTAG_W +: PTAG_W] <= '0;
        ret_btag[g*BTAG_W +: BTAG_W] <= '0;
      end else begin
        ret_valid[g] <= grant[g] && (act == ACT_RUN);
        ret_free[g]  <= grant[g] && (act == ACT_RUN) && slot_data[g*DW + DW - 1];
        ret_ptag[g*PTAG_W +: PTAG_W] <= slot_data[g*DW +: PTAG_W];
        ret_btag[g*BTAG_W +: BTAG_W] <= slot_data[g*DW + PTAG_W +: BTAG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_idx   <= '0;
    end else begin
      exc_valid <= (act == ACT_FLUSH);
      if (act == ACT_FLUSH) exc_idx <= head_idx;
    end
  end
endmodule

// File: rtl/grl_chk.sv
module grl_chk #(
  parameter int DEPTH = 16,
  parameter int RET_W = 2,
  parameter int PW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mis_valid,
  input logic [RET_W-1:0] ret_valid,
  input logic [RET_W-1:0] ret_free,
  input logic             exc_valid,
  input logic [PW-1:0]    head_q,
  input logic [PW-1:0]    tail_q
);
  logic [PW-1:0] occ;
  assign occ = tail_q - head_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ret_valid == '0 && !exc_valid));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= PW'(DEPTH));

  // R5
  ret_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_valid & (ret_valid + RET_W'(1))) == '0);

  // R7
  free_subset_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_free & ~ret_valid) == '0);

  // R8
  trunc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mis_valid |=> (ret_valid == '0));

  // R9
  exc_empty_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (head_q == tail_q && ret_valid == '0));
endmodule

bind inorder_retire_list grl_chk #(
  .DEPTH(DEPTH), .RET_W(RET_W), .PW(IDX_W + 1)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mis_valid (mis_valid),
  .ret_valid (ret_valid),
  .ret_free  (ret_free),
  .exc_valid (exc_valid),
  .head_q    (head_q),
  .tail_q    (tail_q)
);

// File: tb/sim_inorder_retire_list.sv
`timescale 1ns/1ps
module sim_inorder_retire_list;
  localparam int DEPTH = 8, PTAG_W = 6, BTAG_W = 3, RET_W = 2, IDX_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic dec_valid = 0, dec_has_dst = 0, cmp_valid = 0, cmp_exc = 0, mis_valid = 0;
  logic [PTAG_W-1:0] dec_old_ptag = '0;
  logic [BTAG_W-1:0] dec_btag = '0;
  logic [IDX_W-1:0] cmp_idx = '0, mis_idx = '0;
  logic dec_ready, exc_valid;
  logic [IDX_W-1:0] dec_idx, exc_idx;
  logic [RET_W-1:0] ret_valid, ret_free;
  logic [RET_W*PTAG_W-1:0] ret_ptag;
  logic [RET_W*BTAG_W-1:0] ret_btag;

  always #2 clk = ~clk;

  inorder_retire_list #(.DEPTH(DEPTH), .PTAG_W(PTAG_W), .BTAG_W(BTAG_W), .RET_W(RET_W)) u0 (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_old_ptag(dec_old_ptag),
    .dec_has_dst(dec_has_dst), .dec_btag(dec_btag), .dec_ready(dec_ready), .dec_idx(dec_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_exc(cmp_exc),
    .mis_valid(mis_valid), .mis_idx(mis_idx), .ret_valid(ret_valid), .ret_free(ret_free),
    .ret_ptag(ret_ptag), .ret_btag(ret_btag), .exc_valid(exc_valid), .exc_idx(exc_idx));

  int total = 0, bad = 0, ngot = 0;
  logic [PTAG_W-1:0] got [0:31];

  typedef struct packed {
    logic dv; logic [5:0] ptag; logic has; logic cv; logic [2:0] cidx;
    logic [2:0] eidx; logic [1:0] erv; logic [1:0] efree; logic [5:0] ep0; logic [5:0] ep1;
  } vec_t;

  // dv ptag has cv cidx | exp dec_idx, ret_valid, ret_free, ptag0, ptag1
  localparam vec_t TBL [0:7] = '{
    '{1'b1, 6'd10, 1'b1, 1'b0, 3'd0, 3'd0, 2'b00, 2'b00, 6'd0,  6'd0},
    '{1'b1, 6'd11, 1'b1, 1'b1, 3'd0, 3'd1, 2'b00, 2'b00, 6'd0,  6'd0},
    '{1'b1, 6'd12, 1'b0, 1'b0, 3'd0, 3'd2, 2'b01, 2'b01, 6'd10, 6'd0},
    '{1'b1, 6'd13, 1'b1, 1'b1, 3'd2, 3'd3, 2'b00, 2'b00, 6'd0,  6'd0},
    '{1'b0, 6'd0,  1'b0, 1'b1, 3'd1, 3'd0, 2'b00, 2'b00, 6'd0,  6'd0},
    '{1'b0, 6'd0,  1'b0, 1'b0, 3'd0, 3'd0, 2'b11, 2'b01, 6'd11, 6'd12},
    '{1'b0, 6'd0,  1'b0, 1'b1, 3'd3, 3'd0, 2'b00, 2'b00, 6'd0,  6'd0},
    '{1'b0, 6'd0,  1'b0, 1'b0, 3'd0, 3'd0, 2'b01, 2'b01, 6'd13, 6'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let one edge pass, sample at the next negedge.
  task automatic step(input logic dv, input logic [5:0] p, input logic h,
                      input logic cv, input logic [2:0] ci, input logic ce,
                      input logic mv, input logic [2:0] mi);
    dec_valid = dv; dec_old_ptag = p; dec_btag = p[2:0]; dec_has_dst = h;
    cmp_valid = cv; cmp_idx = ci; cmp_exc = ce; mis_valid = mv; mis_idx = mi;
    @(posedge clk);
    @(negedge clk);
    dec_valid = 0; cmp_valid = 0; cmp_exc = 0; mis_valid = 0;
    for (int k = 0; k < RET_W; k++)
      if (ret_valid[k] && ngot < 32) begin
        got[ngot] = ret_ptag[k*PTAG_W +: PTAG_W];
        ngot++;
      end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    check("R1 dec_ready", dec_ready, 1);
    check("R1 ret_valid", ret_valid, 0);
    check("R1 exc_valid", exc_valid, 0);
    check("R1 dec_idx", dec_idx, 0);

    // Table: in-order graduation, multi-slot, registered outputs (R2 R4 R5 R7 R10)
    for (int i = 0; i < 8; i++) begin
      if (TBL[i].dv) check("R2 dec_idx", dec_idx, TBL[i].eidx);
      step(TBL[i].dv, TBL[i].ptag, TBL[i].has, TBL[i].cv, TBL[i].cidx, 0, 0, 0);
      check("R4 R10 ret_valid", ret_valid, TBL[i].erv);
      check("R7 ret_free", ret_free, TBL[i].efree);
      if (TBL[i].erv[0]) begin
        check("R7 ptag0", ret_ptag[5:0], TBL[i].ep0);
        check("R7 btag0", ret_btag[2:0], TBL[i].ep0[2:0]);
      end
      if (TBL[i].erv[1]) check("R5 ptag1", ret_ptag[11:6], TBL[i].ep1);
    end

    // Exception: B (idx5) excepts behind A (idx4), C (idx6) completes too (R6 R9)
    check("R2 dec_idx A", dec_idx, 4);
    step(1, 20, 1, 0, 0, 0, 0, 0);
    step(1, 21, 1, 0, 0, 0, 0, 0);
    step(1, 22, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 5, 1, 0, 0);
    step(0, 0, 0, 1, 6, 0, 0, 0);
    idle();
    check("R9 no exc off head", exc_valid, 0);
    check("R4 nothing past A", ret_valid, 0);
    step(0, 0, 0, 1, 4, 0, 0, 0);
    idle();
    check("R6 only A", ret_valid, 2'b01);
    check("R6 A ptag", ret_ptag[5:0], 20);
    check("R6 exc not yet", exc_valid, 0);
    idle();
    check("R9 exc_valid", exc_valid, 1);
    check("R9 exc_idx", exc_idx, 5);
    check("R9 no retire", ret_valid, 0);
    check("R9 slot reuse", dec_idx, 5);
    idle();
    check("R9 pulse", exc_valid, 0);
    check("R9 C discarded", ret_valid, 0);

    // Misprediction at D (idx5): E, F completed but dropped (R8 R2)
    step(1, 30, 1, 0, 0, 0, 0, 0);
    step(1, 31, 1, 0, 0, 0, 0, 0);
    step(1, 32, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 6, 0, 0, 0);
    step(0, 0, 0, 1, 7, 0, 0, 0);
    step(1, 40, 1, 0, 0, 0, 1, 5);
    check("R8 no retire", ret_valid, 0);
    check("R8 tail cut", dec_idx, 6);
    step(0, 0, 0, 1, 5, 0, 0, 0);
    idle();
    check("R8 D retires", ret_valid, 2'b01);
    check("R8 D ptag", ret_ptag[5:0], 30);
    idle();
    check("R8 E F gone", ret_valid, 0);
    check("R2 reuse idx", dec_idx, 6);
    step(1, 33, 1, 0, 0, 0, 0, 0);
    idle(); idle();
    check("R2 fresh not done", ret_valid, 0);
    step(0, 0, 0, 1, 6, 0, 0, 0);
    idle();
    check("R2 G retires", ret_valid, 2'b01);
    check("R2 G ptag", ret_ptag[5:0], 33);

    // Full list (R3): eight entries at idx 7,0..6, one extra dropped
    ngot = 0;
    for (int i = 0; i < 8; i++) begin
      check("R2 full dec_idx", dec_idx, (7 + i) % 8);
      step(1, 6'(50 + i), 1, 0, 0, 0, 0, 0);
    end
    check("R3 dec_ready low", dec_ready, 0);
    step(1, 60, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 3'((7 + i) % 8), 0, 0, 0);
    for (int i = 0; i < 4; i++) idle();
    check("R3 retire count", ngot, 8);
    for (int i = 0; i < 8; i++) check("R3 R4 order", got[i], 50 + i);
    check("R3 ready again", dec_ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule